// File: doc/BRIEF.md
# Channel Interrupt Mask Controller

This block gathers the interrupt requests of a multi-channel packet DMA engine and presents them to a processor as one interrupt line. The requests arrive as level signals in three groups. The transmit group and the receive group each carry one line per channel. A small DMA-level group carries engine-wide conditions, and its bit 1 is the host-error source. Software enables individual sources through paired write-one-to-set and write-one-to-clear mask registers, so a mask is never changed by a read-modify-write sequence. For each group, software can read the unfiltered request levels and the filtered view.

Access is through a plain 32-bit register port. The port has one-cycle write strobes and a read strobe whose data is registered and returned one cycle later. It uses a fixed 8-bit byte-offset decode. Two direction-enable registers drive the transmit and receive run outputs. A read-only vector register reports which groups have enabled requests pending. An end-of-interrupt register drops the interrupt line for one cycle, so that a source that is still pending gives the interrupt controller a fresh rising edge.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After synchronous reset, every mask bit is 0, both run outputs are 0, the interrupt output is 0, and the read data is 0.
- R2: A write to the set offset of a group (transmit 0x88, receive 0xA8, DMA 0xB8) sets each mask bit whose write-data bit is 1 and leaves the mask bits written with 0 unchanged. A read of the set offset or the clear offset returns the group's current mask.
- R3: A write to the clear offset of a group (transmit 0x8C, receive 0xAC, DMA 0xBC) clears each mask bit whose write-data bit is 1 and leaves the others unchanged. Writing all ones disables every source in the group.
- R4: Channel n uses bit n of its group's registers. A read of the raw offset (0x80, 0xA0, 0xB0) returns the request inputs. A read of the masked offset (0x84, 0xA4, 0xB4) returns the request inputs AND the mask. Bits above the group width read as 0.
- R5: The raw, masked and vector offsets are read-only. Writes to them leave every mask and every output unchanged.
- R6: The DMA group is DMA_W bits wide (2 by default), and its bit 1 is the host-error source. When that bit is masked in and requested, it raises the interrupt on its own.
- R7: The interrupt output is a register. In the cycle after an edge at which any masked bit of any group is 1, it is 1. In the cycle after an edge at which every masked bit is 0, it is 0.
- R8: A write to offset 0x94 (end of interrupt) forces the interrupt output to 0 for the single cycle after that write, whatever is pending. Afterwards the output follows R7 again. Reads of 0x94 return 0.
- R9: A read of offset 0x90 returns the pending vector: bit 0 = any transmit masked bit, bit 1 = any receive masked bit, bit 2 = any DMA masked bit, all other bits 0.
- R10: Bit 0 of offset 0x04 is the transmit enable and bit 0 of offset 0x14 is the receive enable. Writing 1 sets the enable and writing 0 clears it. The registers read back that bit and drive tx_run and rx_run.
- R11: Read data appears on rdata in the cycle after rd_en and is 0 in a cycle after no read. A read of any offset not listed above returns 0. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| tx_src | input | NCH | Transmit channel request levels |
| rx_src | input | NCH | Receive channel request levels |
| dma_src | input | DMA_W | DMA-level request levels, bit 1 host error |
| tx_run | output | 1 | Transmit direction enable |
| rx_run | output | 1 | Receive direction enable |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions check the following on every cycle. After a set write, the written ones are present in the mask and the bits written with 0 are unchanged. After a clear write, the written ones are gone. A mask with no write addressed to it stays stable. An end-of-interrupt write pulls the line low in the next cycle. The line is never high without a pending masked request in the cycle before. A run output follows the bit 0 last written to its control register. An unmapped read returns zero. The bench scenarios cover what the assertions cannot: the read-back values of each offset against a model, the raw and masked views under changing inputs, the vector encoding, writes to read-only offsets having no effect, a read and a write in the same cycle, and the interrupt line returning after its end-of-interrupt gap.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int REG_W = 32;
  localparam int OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_TX_CTL  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_RX_CTL  = 8'h14;
  localparam logic [OFS_W-1:0] OFS_TX_RAW  = 8'h80;
  localparam logic [OFS_W-1:0] OFS_TX_MSKD = 8'h84;
  localparam logic [OFS_W-1:0] OFS_TX_SET  = 8'h88;
  localparam logic [OFS_W-1:0] OFS_TX_CLR  = 8'h8C;
  localparam logic [OFS_W-1:0] OFS_VEC     = 8'h90;
  localparam logic [OFS_W-1:0] OFS_EOI     = 8'h94;
  localparam logic [OFS_W-1:0] OFS_RX_RAW  = 8'hA0;
  localparam logic [OFS_W-1:0] OFS_RX_MSKD = 8'hA4;
  localparam logic [OFS_W-1:0] OFS_RX_SET  = 8'hA8;
  localparam logic [OFS_W-1:0] OFS_RX_CLR  = 8'hAC;
  localparam logic [OFS_W-1:0] OFS_DM_RAW  = 8'hB0;
  localparam logic [OFS_W-1:0] OFS_DM_MSKD = 8'hB4;
  localparam logic [OFS_W-1:0] OFS_DM_SET  = 8'hB8;
  localparam logic [OFS_W-1:0] OFS_DM_CLR  = 8'hBC;

  // Vector bit positions, one per group
  localparam int VEC_TX  = 0;
  localparam int VEC_RX  = 1;
  localparam int VEC_DMA = 2;
  localparam int VEC_W   = 3;

  typedef struct packed {
    logic set_we;
    logic clr_we;
  } mask_wr_t;

  // Offsets that return data on a read (end-of-interrupt is write-only)
  function automatic logic rd_mapped(input logic [OFS_W-1:0] a);
    case (a)
      OFS_TX_CTL, OFS_RX_CTL, OFS_VEC,
      OFS_TX_RAW, OFS_TX_MSKD, OFS_TX_SET, OFS_TX_CLR,
      OFS_RX_RAW, OFS_RX_MSKD, OFS_RX_SET, OFS_RX_CLR,
      OFS_DM_RAW, OFS_DM_MSKD, OFS_DM_SET, OFS_DM_CLR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_mask_group.sv
module irq_mask_group
  import irq_ctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mask_wr_t     wr,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] raw,
  output logic [W-1:0] mask,
  output logic [W-1:0] masked,
  output logic         any
);

  logic [W-1:0] mask_q;
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign set_bits = wr.set_we ? wbits : '0;
  assign clr_bits = wr.clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | set_bits) & ~clr_bits;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign masked[i] = raw[i] & mask_q[i];
    end
  endgenerate

  assign mask = mask_q;
  assign any  = |masked;

  // R2
  set_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr.set_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
  // R2
  set_keep_chk: assert property (@(posedge clk) disable iff (rst)
    wr.set_we |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));
  // R3
  clr_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr.clr_we |=> ((mask_q & $past(wbits)) == '0));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr.set_we && !wr.clr_we) |=> $stable(mask_q));

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic eoi_wr,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (eoi_wr) irq_q <= 1'b0;
    else             irq_q <= pend;
  end

  assign irq = irq_q;

  // R8
  eoi_gap_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_wr |=> !irq_q);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(pend));

endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_ctl_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DMA_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [NCH-1:0]   tx_raw,
  input  logic [NCH-1:0]   tx_mask,
  input  logic [NCH-1:0]   tx_mskd,
  input  logic [NCH-1:0]   rx_raw,
  input  logic [NCH-1:0]   rx_mask,
  input  logic [NCH-1:0]   rx_mskd,
  input  logic [DMA_W-1:0] dm_raw,
  input  logic [DMA_W-1:0] dm_mask,
  input  logic [DMA_W-1:0] dm_mskd,
  input  logic [VEC_W-1:0] vec,
  input  logic             tx_run,
  input  logic             rx_run,
  output logic [REG_W-1:0] rdata
);

  logic [REG_W-1:0] rd_q;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    case (addr)
      OFS_TX_CTL:              rd_mux = REG_W'(tx_run);
      OFS_RX_CTL:              rd_mux = REG_W'(rx_run);
      OFS_VEC:                 rd_mux = REG_W'(vec);
      OFS_TX_RAW:              rd_mux = REG_W'(tx_raw);
      OFS_TX_MSKD:             rd_mux = REG_W'(tx_mskd);
      OFS_TX_SET, OFS_TX_CLR:  rd_mux = REG_W'(tx_mask);
      OFS_RX_RAW:              rd_mux = REG_W'(rx_raw);
      OFS_RX_MSKD:             rd_mux = REG_W'(rx_mskd);
      OFS_RX_SET, OFS_RX_CLR:  rd_mux = REG_W'(rx_mask);
      OFS_DM_RAW:              rd_mux = REG_W'(dm_raw);
      OFS_DM_MSKD:             rd_mux = REG_W'(dm_mskd);
      OFS_DM_SET, OFS_DM_CLR:  rd_mux = REG_W'(dm_mask);
      default:                 rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
    else            rd_q <= '0;
  end

  assign rdata = rd_q;

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_mapped(addr)) |=> (rdata == '0));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DMA_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NCH-1:0]   tx_src,
  input  logic [NCH-1:0]   rx_src,
  input  logic [DMA_W-1:0] dma_src,
  output logic             tx_run,
  output logic             rx_run,
  output logic             irq
);

  mask_wr_t         tx_wr, rx_wr, dm_wr;
  logic [NCH-1:0]   tx_mask, tx_mskd, rx_mask, rx_mskd;
  logic [DMA_W-1:0] dm_mask, dm_mskd;
  logic             tx_any, rx_any, dm_any;
  logic [VEC_W-1:0] vec;
  logic             eoi_wr;
  logic             tx_run_q, rx_run_q;
  logic             unused_wdata;

  assign tx_wr.set_we = wr_en && (addr == OFS_TX_SET);
  assign tx_wr.clr_we = wr_en && (addr == OFS_TX_CLR);
  assign rx_wr.set_we = wr_en && (addr == OFS_RX_SET);
  assign rx_wr.clr_we = wr_en && (addr == OFS_RX_CLR);
  assign dm_wr.set_we = wr_en && (addr == OFS_DM_SET);
  assign dm_wr.clr_we = wr_en && (addr == OFS_DM_CLR);
  assign eoi_wr       = wr_en && (addr == OFS_EOI);
  assign unused_wdata = ^wdata;

  irq_mask_group #(.W(NCH)) u_tx (
    .clk(clk), .rst(rst), .wr(tx_wr), .wbits(wdata[NCH-1:0]), .raw(tx_src),
    .mask(tx_mask), .masked(tx_mskd), .any(tx_any));

  irq_mask_group #(.W(NCH)) u_rx (
    .clk(clk), .rst(rst), .wr(rx_wr), .wbits(wdata[NCH-1:0]), .raw(rx_src),
    .mask(rx_mask), .masked(rx_mskd), .any(rx_any));

  irq_mask_group #(.W(DMA_W)) u_dm (
    .clk(clk), .rst(rst), .wr(dm_wr), .wbits(wdata[DMA_W-1:0]), .raw(dma_src),
    .mask(dm_mask), .masked(dm_mskd), .any(dm_any));

  always_comb begin
    vec          = '0;
    vec[VEC_TX]  = tx_any;
    vec[VEC_RX]  = rx_any;
    vec[VEC_DMA] = dm_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_run_q <= 1'b0;
      rx_run_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFS_TX_CTL) tx_run_q <= wdata[0];
      if (addr == OFS_RX_CTL) rx_run_q <= wdata[0];
    end
  end

  assign tx_run = tx_run_q;
  assign rx_run = rx_run_q;

  irq_out_gen u_irq (
    .clk(clk), .rst(rst), .pend(|vec), .eoi_wr(eoi_wr), .irq(irq));

  irq_reg_read #(.NCH(NCH), .DMA_W(DMA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .tx_raw(tx_src), .tx_mask(tx_mask), .tx_mskd(tx_mskd),
    .rx_raw(rx_src), .rx_mask(rx_mask), .rx_mskd(rx_mskd),
    .dm_raw(dma_src), .dm_mask(dm_mask), .dm_mskd(dm_mskd),
    .vec(vec), .tx_run(tx_run_q), .rx_run(rx_run_q), .rdata(rdata));

  // R10
  tx_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_TX_CTL) |=> (tx_run == $past(wdata[0])));
  // R10
  rx_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_RX_CTL) |=> (rx_run == $past(wdata[0])));
  // R6
  host_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!eoi_wr && dm_mask[1] && dma_src[1]) |=> irq);

endmodule

// File: tb/irq_mask_ctrl_test.sv
module irq_mask_ctrl_test;

  localparam int NCH   = 8;
  localparam int DMA_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [NCH-1:0]   tx_src = '0, rx_src = '0;
  logic [DMA_W-1:0] dma_src = '0;
  logic             tx_run, rx_run, irq;

  int unsigned checks = 0;
  int unsigned bad = 0;
  bit          done = 1'b0;

  // reference state
  logic [NCH-1:0]   m_tx = '0, m_rx = '0;
  logic [DMA_W-1:0] m_dm = '0;
  logic             m_txr = 1'b0, m_rxr = 1'b0;

  irq_mask_ctrl #(.NCH(NCH), .DMA_W(DMA_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_src(tx_src), .rx_src(rx_src),
    .dma_src(dma_src), .tx_run(tx_run), .rx_run(rx_run), .irq(irq));

  always #10 clk = ~clk;

  function automatic logic [2:0] model_vec();
    return {|(m_dm & dma_src), |(m_rx & rx_src), |(m_tx & tx_src)};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h04: return 32'(m_txr);
      8'h14: return 32'(m_rxr);
      8'h90: return 32'(model_vec());
      8'h80: return 32'(tx_src);
      8'h84: return 32'(tx_src & m_tx);
      8'h88, 8'h8C: return 32'(m_tx);
      8'hA0: return 32'(rx_src);
      8'hA4: return 32'(rx_src & m_rx);
      8'hA8, 8'hAC: return 32'(m_rx);
      8'hB0: return 32'(dma_src);
      8'hB4: return 32'(dma_src & m_dm);
      8'hB8, 8'hBC: return 32'(m_dm);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h04, 8'h14: return "R10";
      8'h90: return "R9";
      8'h88, 8'hA8, 8'hB8: return "R2";
      8'h8C, 8'hAC, 8'hBC: return "R3";
      8'hB0, 8'hB4: return "R6";
      8'h80, 8'h84, 8'hA0, 8'hA4: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive after a falling edge, sample at the next falling edge
  task automatic step(input bit we, input bit re, input logic [7:0] a,
                      input logic [31:0] d, input string irq_tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    wr_en = we; rd_en = re; addr = a; wdata = d;
    exp_rd  = re ? model_read(a) : 32'h0;
    exp_irq = (we && a == 8'h94) ? 1'b0 : |model_vec();
    if (we) begin
      case (a)
        8'h88: m_tx = m_tx | d[NCH-1:0];
        8'h8C: m_tx = m_tx & ~d[NCH-1:0];
        8'hA8: m_rx = m_rx | d[NCH-1:0];
        8'hAC: m_rx = m_rx & ~d[NCH-1:0];
        8'hB8: m_dm = m_dm | d[DMA_W-1:0];
        8'hBC: m_dm = m_dm & ~d[DMA_W-1:0];
        8'h04: m_txr = d[0];
        8'h14: m_rxr = d[0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(irq_tag, 32'(irq), 32'(exp_irq));
    check(re ? read_tag(a) : "R11", rdata, exp_rd);
    if (we && (a == 8'h04 || a == 8'h14)) begin
      check("R10", 32'({tx_run, rx_run}), 32'({m_txr, m_rxr}));
    end
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [7:0] alist [16];
    alist = '{8'h04, 8'h14, 8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94,
              8'hA4, 8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC, 8'h40};
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'({irq, tx_run, rx_run}), 32'h0);
    check("R1", rdata, 32'h0);
    rst = 1'b0;
    step(0, 1, 8'h88, 0, "R1");
    step(0, 1, 8'hB8, 0, "R1");
    // R2/R4: set mask bits, read masked view
    tx_src = 8'h05;
    step(1, 0, 8'h88, 32'h0000_0003, "R7");
    step(0, 1, 8'h84, 0, "R4");
    step(0, 1, 8'h90, 0, "R9");
    // R5: writes to raw, masked and vector offsets are ignored
    step(1, 0, 8'h80, 32'hFFFF_FFFF, "R5");
    step(1, 0, 8'h84, 32'hFFFF_FFFF, "R5");
    step(1, 0, 8'h90, 32'hFFFF_FFFF, "R5");
    step(0, 1, 8'h88, 0, "R5");
    step(0, 1, 8'h80, 0, "R5");
    // R8: end of interrupt gap with source still pending, then back high
    step(1, 0, 8'h94, 32'h0000_0001, "R8");
    step(0, 1, 8'h94, 0, "R8");
    // R3: clear all ones removes the interrupt
    step(1, 0, 8'h8C, 32'hFFFF_FFFF, "R3");
    step(0, 1, 8'h8C, 0, "R3");
    // R6: host-error bit alone raises the interrupt
    dma_src = 2'b10;
    step(1, 0, 8'hB8, 32'h0000_0002, "R6");
    step(0, 1, 8'h90, 0, "R6");
    step(1, 0, 8'hBC, 32'h0000_0002, "R6");
    // R11: read and write in the same cycle return the old value
    step(1, 1, 8'hA8, 32'h0000_00F0, "R11");
    step(0, 1, 8'hA8, 0, "R11");
    step(0, 1, 8'hFC, 0, "R11");
    // R10: direction enables
    step(1, 0, 8'h04, 32'h1, "R10");
    step(1, 0, 8'h14, 32'h1, "R10");
    step(1, 0, 8'h04, 32'h0, "R10");
    // random mixture
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      bit we, re;
      a  = alist[$urandom_range(15)];
      d  = $urandom();
      if ($urandom_range(3) == 0) d = 32'hFFFF_FFFF;
      we = ($urandom_range(1) == 1);
      re = ($urandom_range(2) != 0);
      if ($urandom_range(3) == 0) tx_src = NCH'($urandom());
      if ($urandom_range(3) == 0) rx_src = NCH'($urandom());
      if ($urandom_range(3) == 0) dma_src = DMA_W'($urandom());
      step(we, re, a, d, (we && a == 8'h94) ? "R8" : "R7");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule